// File: doc/BRIEF.md
# Multi-Register Stack Transfer Sequencer

This block turns one decoded "save a run of registers to the stack" or "restore a run of registers from the stack" instruction into a stream of simple micro-operations. Each register in a contiguous index range gets one memory micro-operation, a store for a push or a load for a pop, and each carries its own byte address. After all of them, the block emits one micro-operation that moves the stack pointer by the total size of the transfer.

Each instruction chooses the stack direction for itself from an option byte. The same byte also gives the last register index of the range. The element size is a power of two. The address pattern depends on whether the stack grows toward higher or lower addresses. A pop restores registers in the reverse order of a push, so the sequence always mirrors the layout that a push of the same range produced.

The micro-op stream uses a valid/ready handshake. A new instruction is taken only while the sequencer is idle, which means after its last micro-operation has been accepted.

Top module: `stkseq_top`

## Requirements
- R1: The last register index is `opt_byte[4:0]`. The range covers every index from `first_reg` to that last index, both ends included. The count is last − first + 1.
- R2: A push reads its grows-upward flag from `opt_byte[7]`, and a pop reads it from `opt_byte[6]`. A value of 1 means the stack grows toward higher addresses. The other direction bit has no effect.
- R3: The element size is 2^`log_size` bytes. Every memory address lies at a whole multiple of that size from the stack pointer value captured at start.
- R4: A push on an upward stack stores the register at position i (i = reg − first) to SP + i·size, for registers first, first+1, … last.
- R5: A push on a downward stack stores the register at position i to SP − (i+1)·size.
- R6: A pop visits registers from last down to first. Position i is last − reg.
- R7: A pop from a downward stack loads position i from SP + i·size. A pop from an upward stack loads it from SP − (i+1)·size.
- R8: Exactly one pointer-update micro-op follows the memory micro-ops. Its `uop_reg` is the stack-pointer index, its `uop_addr` is 0, and its `uop_imm` is count << `log_size`. Its kind is 2 (add) for an upward push or a downward pop, and 3 (subtract) otherwise. Memory micro-ops have kind 0 (store) or 1 (load), with `uop_imm` = 0.
- R9: When the last index is below the first, no memory micro-op is emitted. Only the pointer update is emitted, with `uop_imm` = 0.
- R10: While `uop_valid` is high and `uop_ready` is low, every micro-op output holds its value.
- R11: `start_ready` is high only while idle. A `start` request while busy is ignored and does not change the ongoing sequence.
- R12: After reset, `uop_valid` is 0 and `start_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a new instruction |
| start_ready | output | 1 | High when idle and able to take an instruction |
| is_pop | input | 1 | 1 selects pop, 0 selects push |
| first_reg | input | 5 | First data register index |
| opt_byte | input | 8 | Last index and direction flags |
| sp_idx | input | 5 | Stack-pointer register index |
| sp_value | input | 32 | Current stack-pointer value |
| log_size | input | 2 | log2 of element size in bytes |
| uop_valid | output | 1 | Micro-op available |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_kind | output | 2 | 0 store, 1 load, 2 pointer add, 3 pointer subtract |
| uop_reg | output | 5 | Register index of the micro-op |
| uop_addr | output | 32 | Byte address of a memory micro-op |
| uop_imm | output | 32 | Pointer adjustment amount |

## Verification
A new `start` request can arrive in the same cycle that the sequencer is still delivering a micro-op, including during the final pointer update. The bench provokes this by raising `start` with different operands in the middle of a sequence, while back-pressure stretches the sequence out. The check is that `start_ready` stays low and that every later micro-op still matches the values computed from the original instruction. The bench also confirms that the block goes idle exactly one cycle after the pointer update is taken.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

  typedef enum logic [1:0] {
    UOP_STORE  = 2'd0,
    UOP_LOAD   = 2'd1,
    UOP_SP_ADD = 2'd2,
    UOP_SP_SUB = 2'd3
  } uop_kind_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_MEM  = 2'd1,
    SQ_UPD  = 2'd2
  } seq_state_t;

  // Ascending layout: a push grows upward, or a pop unwinds a downward stack.
  function automatic logic stack_ascends(input logic pop, input logic [7:0] opt);
    return pop ? ~opt[6] : opt[7];
  endfunction

endpackage

// File: rtl/stkseq_decode.sv
module stkseq_decode #(
  parameter int REG_W = 5,
  parameter int AW    = 32,
  parameter int LSZ_W = 2,
  localparam int CNT_W = REG_W + 1
) (
  input  logic             is_pop,
  input  logic [REG_W-1:0] first_reg,
  input  logic [7:0]       opt_byte,
  input  logic [LSZ_W-1:0] log_size,
  output logic [REG_W-1:0] last_reg,
  output logic             ascending,
  output logic [CNT_W-1:0] count,
  output logic [AW-1:0]    upd_imm
);
  import stkseq_pkg::*;

  always_comb begin
    last_reg  = opt_byte[REG_W-1:0];
    ascending = stack_ascends(is_pop, opt_byte);
    if (last_reg >= first_reg)
      count = {1'b0, last_reg} - {1'b0, first_reg} + CNT_W'(1);
    else
      count = '0;
    upd_imm = AW'(count) << log_size;
  end

endmodule

// File: rtl/stkseq_agen.sv
module stkseq_agen #(
  parameter int REG_W = 5,
  parameter int AW    = 32,
  parameter int LSZ_W = 2,
  localparam int CNT_W = REG_W + 1
) (
  input  logic             pop,
  input  logic             ascending,
  input  logic [REG_W-1:0] first_reg,
  input  logic [REG_W-1:0] last_reg,
  input  logic [AW-1:0]    sp_base,
  input  logic [LSZ_W-1:0] log_size,
  input  logic [CNT_W-1:0] pos,
  output logic [REG_W-1:0] reg_idx,
  output logic [AW-1:0]    mem_addr
);

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base,
                                               input logic [CNT_W-1:0] p,
                                               input logic [LSZ_W-1:0] lsz,
                                               input logic up);
    logic [AW-1:0] off;
    off = AW'(p) << lsz;
    if (up) return base + off;
    return base - (off + (AW'(1) << lsz));
  endfunction

  always_comb begin
    if (pop) reg_idx = last_reg - pos[REG_W-1:0];
    else     reg_idx = first_reg + pos[REG_W-1:0];
    mem_addr = slot_addr(sp_base, pos, log_size, ascending);
  end

endmodule

// File: rtl/stkseq_ctrl.sv
module stkseq_ctrl #(
  parameter int REG_W = 5,
  localparam int CNT_W = REG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CNT_W-1:0] count_in,
  input  logic             uop_ready,
  output stkseq_pkg::seq_state_t state,
  output logic [CNT_W-1:0] pos,
  output logic             fire,
  output logic             done
);
  import stkseq_pkg::*;

  logic [CNT_W-1:0] count_q;
  logic             last_mem;

  assign fire     = (state != SQ_IDLE) && uop_ready;
  assign done     = (state == SQ_UPD) && uop_ready;
  assign last_mem = (pos == count_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      pos     <= '0;
      count_q <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (accept) begin
          count_q <= count_in;
          pos     <= '0;
          state   <= (count_in == '0) ? SQ_UPD : SQ_MEM;
        end
        SQ_MEM: if (uop_ready) begin
          if (last_mem) state <= SQ_UPD;
          else          pos   <= pos + CNT_W'(1);
        end
        SQ_UPD: if (uop_ready) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/stkseq_top.sv
module stkseq_top #(
  parameter int REG_W = 5,
  parameter int AW    = 32,
  parameter int LSZ_W = 2,
  localparam int CNT_W = REG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             start_ready,
  input  logic             is_pop,
  input  logic [REG_W-1:0] first_reg,
  input  logic [7:0]       opt_byte,
  input  logic [REG_W-1:0] sp_idx,
  input  logic [AW-1:0]    sp_value,
  input  logic [LSZ_W-1:0] log_size,
  output logic             uop_valid,
  input  logic             uop_ready,
  output logic [1:0]       uop_kind,
  output logic [REG_W-1:0] uop_reg,
  output logic [AW-1:0]    uop_addr,
  output logic [AW-1:0]    uop_imm
);
  import stkseq_pkg::*;

  logic [REG_W-1:0] dec_last;
  logic             dec_asc;
  logic [CNT_W-1:0] dec_count;
  logic [AW-1:0]    dec_imm;

  logic             op_pop, op_asc;
  logic [REG_W-1:0] op_first, op_last, op_spidx;
  logic [AW-1:0]    op_sp, op_imm;
  logic [LSZ_W-1:0] op_lsz;

  seq_state_t       state;
  logic [CNT_W-1:0] pos;
  logic             seq_accept, seq_fire, seq_done;
  logic [REG_W-1:0] ag_reg;
  logic [AW-1:0]    ag_addr;

  assign start_ready = (state == SQ_IDLE);
  assign seq_accept  = start && start_ready;

  stkseq_decode #(.REG_W(REG_W), .AW(AW), .LSZ_W(LSZ_W)) u_dec (
    .is_pop    (is_pop),
    .first_reg (first_reg),
    .opt_byte  (opt_byte),
    .log_size  (log_size),
    .last_reg  (dec_last),
    .ascending (dec_asc),
    .count     (dec_count),
    .upd_imm   (dec_imm)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_pop   <= 1'b0;
      op_asc   <= 1'b0;
      op_first <= '0;
      op_last  <= '0;
      op_spidx <= '0;
      op_sp    <= '0;
      op_imm   <= '0;
      op_lsz   <= '0;
    end else if (seq_accept) begin
      op_pop   <= is_pop;
      op_asc   <= dec_asc;
      op_first <= first_reg;
      op_last  <= dec_last;
      op_spidx <= sp_idx;
      op_sp    <= sp_value;
      op_imm   <= dec_imm;
      op_lsz   <= log_size;
    end
  end

  stkseq_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (seq_accept),
    .count_in  (dec_count),
    .uop_ready (uop_ready),
    .state     (state),
    .pos       (pos),
    .fire      (seq_fire),
    .done      (seq_done)
  );

  stkseq_agen #(.REG_W(REG_W), .AW(AW), .LSZ_W(LSZ_W)) u_agen (
    .pop       (op_pop),
    .ascending (op_asc),
    .first_reg (op_first),
    .last_reg  (op_last),
    .sp_base   (op_sp),
    .log_size  (op_lsz),
    .pos       (pos),
    .reg_idx   (ag_reg),
    .mem_addr  (ag_addr)
  );

  always_comb begin
    uop_valid = 1'b0;
    uop_kind  = UOP_STORE;
    uop_reg   = '0;
    uop_addr  = '0;
    uop_imm   = '0;
    case (state)
      SQ_MEM: begin
        uop_valid = 1'b1;
        uop_kind  = op_pop ? UOP_LOAD : UOP_STORE;
        uop_reg   = ag_reg;
        uop_addr  = ag_addr;
      end
      SQ_UPD: begin
        uop_valid = 1'b1;
        uop_kind  = op_asc ? UOP_SP_ADD : UOP_SP_SUB;
        uop_reg   = op_spidx;
        uop_imm   = op_imm;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/stkseq_chk.sv
module stkseq_chk #(
  parameter int REG_W = 5,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_ready,
  input logic             uop_valid,
  input logic             uop_ready,
  input logic [1:0]       uop_kind,
  input logic [REG_W-1:0] uop_reg,
  input logic [AW-1:0]    uop_addr,
  input logic [AW-1:0]    uop_imm,
  input logic             seq_fire,
  input logic             seq_done
);
  import stkseq_pkg::*;

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_ready |=> uop_valid && $stable(uop_kind) && $stable(uop_reg)
                                && $stable(uop_addr) && $stable(uop_imm));

  a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> !start_ready);

  a_r8_idle_after_update: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> start_ready && !uop_valid);

  a_r8_mem_imm_zero: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && (uop_kind == UOP_STORE || uop_kind == UOP_LOAD) |-> uop_imm == '0);

  a_r4_push_ascending_regs: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fire && uop_kind == UOP_STORE |=>
      (uop_kind != UOP_STORE) || (uop_reg == $past(uop_reg) + 1'b1));

  a_r6_pop_descending_regs: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fire && uop_kind == UOP_LOAD |=>
      (uop_kind != UOP_LOAD) || (uop_reg == $past(uop_reg) - 1'b1));

  a_r12_reset_idle: assert property (@(posedge clk)
    !rst_n |=> start_ready && !uop_valid);

endmodule

bind stkseq_top stkseq_chk #(.REG_W(REG_W), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_ready (start_ready),
  .uop_valid   (uop_valid),
  .uop_ready   (uop_ready),
  .uop_kind    (uop_kind),
  .uop_reg     (uop_reg),
  .uop_addr    (uop_addr),
  .uop_imm     (uop_imm),
  .seq_fire    (seq_fire),
  .seq_done    (seq_done)
);

// File: tb/stkseq_top_test.sv
module stkseq_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        start_ready;
  logic        is_pop = 1'b0;
  logic [4:0]  first_reg = '0;
  logic [7:0]  opt_byte = '0;
  logic [4:0]  sp_idx = '0;
  logic [31:0] sp_value = '0;
  logic [1:0]  log_size = '0;
  logic        uop_valid;
  logic        uop_ready = 1'b0;
  logic [1:0]  uop_kind;
  logic [4:0]  uop_reg;
  logic [31:0] uop_addr;
  logic [31:0] uop_imm;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  stkseq_top uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ready(start_ready),
    .is_pop(is_pop), .first_reg(first_reg), .opt_byte(opt_byte), .sp_idx(sp_idx),
    .sp_value(sp_value), .log_size(log_size), .uop_valid(uop_valid),
    .uop_ready(uop_ready), .uop_kind(uop_kind), .uop_reg(uop_reg),
    .uop_addr(uop_addr), .uop_imm(uop_imm)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Runs one instruction and compares every micro-op with values computed here.
  task automatic run_op(input bit pop, input logic [4:0] first, input logic [7:0] opt,
                        input logic [4:0] spi, input logic [31:0] sp,
                        input logic [1:0] lsz, input bit stall, input bit poke,
                        input string req);
    int last, cnt, n, cyc;
    bit up;
    logic [31:0] size;
    logic [1:0]  ekind;
    logic [4:0]  ereg;
    logic [31:0] eaddr, eimm;
    last = int'(opt[4:0]);
    cnt  = (last >= int'(first)) ? last - int'(first) + 1 : 0;
    up   = pop ? (opt[6] == 1'b0) : (opt[7] == 1'b1);
    size = 32'd1 << lsz;
    @(negedge clk);
    check(start_ready == 1'b1, "R11", "ready before start", 64'(start_ready), 64'd1);
    is_pop = pop; first_reg = first; opt_byte = opt; sp_idx = spi;
    sp_value = sp; log_size = lsz; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    is_pop = ~pop; first_reg = 5'd0; opt_byte = 8'hDF; sp_idx = 5'd9; sp_value = 32'hDEAD0000;
    n = 0; cyc = 0;
    while (n <= cnt && cyc < 400) begin
      uop_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      start = (poke && (cyc == 1 || cyc == 2 || n == cnt));
      if (uop_valid) begin
        check(start_ready == 1'b0, "R11", "busy ready", 64'(start_ready), 64'd0);
        if (uop_ready) begin
          if (n < cnt) begin
            ekind = pop ? 2'd1 : 2'd0;
            ereg  = pop ? 5'(last - n) : 5'(int'(first) + n);
            eaddr = up ? sp + 32'(n) * size : sp - 32'(n + 1) * size;
            eimm  = 32'd0;
          end else begin
            ekind = up ? 2'd2 : 2'd3;
            ereg  = spi;
            eaddr = 32'd0;
            eimm  = 32'(cnt) * size;
          end
          check(uop_kind == ekind, req, "kind", 64'(uop_kind), 64'(ekind));
          check(uop_reg == ereg, req, "reg", 64'(uop_reg), 64'(ereg));
          check(uop_addr == eaddr, req, "addr", 64'(uop_addr), 64'(eaddr));
          check(uop_imm == eimm, req, "imm", 64'(uop_imm), 64'(eimm));
          n++;
        end
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    uop_ready = 1'b0;
    check(n == cnt + 1, req, "micro-op count", 64'(n), 64'(cnt + 1));
    check(uop_valid == 1'b0 && start_ready == 1'b1, "R8", "idle after update",
          64'({uop_valid, start_ready}), 64'b01);
  endtask

  task automatic t_reset;
    check(uop_valid == 1'b0, "R12", "valid in reset", 64'(uop_valid), 64'd0);
    check(start_ready == 1'b1, "R12", "ready in reset", 64'(start_ready), 64'd1);
  endtask

  task automatic t_push_up;      // R1 R3 R4 R8
    run_op(1'b0, 5'd3, 8'h87, 5'd31, 32'h1000, 2'd3, 1'b0, 1'b0, "R4");
  endtask
  task automatic t_push_down;    // R5 R10, bit6 ignored on push: R2
    run_op(1'b0, 5'd0, 8'h44, 5'd2, 32'h2000, 2'd2, 1'b1, 1'b0, "R5");
  endtask
  task automatic t_pop_down;     // R6 R7, bit7 ignored on pop: R2
    run_op(1'b1, 5'd2, 8'h85, 5'd31, 32'h3000, 2'd3, 1'b0, 1'b0, "R7");
  endtask
  task automatic t_pop_up;       // R6 R7 R10
    run_op(1'b1, 5'd6, 8'h49, 5'd4, 32'h4000, 2'd1, 1'b1, 1'b0, "R6");
  endtask
  task automatic t_dir_bits;     // R2
    run_op(1'b0, 5'd1, 8'h43, 5'd7, 32'h500, 2'd0, 1'b0, 1'b0, "R2");
    run_op(1'b1, 5'd1, 8'hC3, 5'd7, 32'h500, 2'd0, 1'b0, 1'b0, "R2");
  endtask
  task automatic t_empty;        // R9
    run_op(1'b0, 5'd10, 8'h85, 5'd29, 32'h6000, 2'd2, 1'b0, 1'b0, "R9");
    run_op(1'b1, 5'd20, 8'h03, 5'd29, 32'h6000, 2'd3, 1'b1, 1'b0, "R9");
  endtask
  task automatic t_full_and_wrap; // R1 R3
    run_op(1'b0, 5'd31, 8'h1F, 5'd1, 32'h0000_0004, 2'd3, 1'b0, 1'b0, "R3");
    run_op(1'b0, 5'd0, 8'h9F, 5'd1, 32'hFFFF_FFF0, 2'd2, 1'b1, 1'b0, "R1");
  endtask
  task automatic t_busy_start;   // R11
    run_op(1'b1, 5'd4, 8'h0B, 5'd3, 32'h7000, 2'd2, 1'b1, 1'b1, "R11");
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_push_up();
    t_push_down();
    t_pop_down();
    t_pop_up();
    t_dir_bits();
    t_empty();
    t_full_and_wrap();
    t_busy_start();
    t_push_up();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule